// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Qualification

This block turns a stream of signed temperature results into a single alert output. Each completed conversion arrives as a 12-bit two's-complement value with a one-cycle valid strobe. The block compares that value against a programmable upper limit and a programmable lower limit. At any time only one of the two limits is armed. A result counts as a fault when it is at or above the upper limit while the upper limit is armed, or below the lower limit while the lower limit is armed.

Faults pass through a queue that needs a programmable number of back-to-back faulting results before it acts. When the queue trips, the armed limit swaps. In comparator mode the alert follows the armed limit, which gives a hysteretic thermostat output. In interrupt mode every trip latches the alert, and a read-acknowledge pulse clears it. A polarity input selects whether the output pin is active high or active low.

Top module: `therm_alert`

## Requirements
- R1: After reset the alert is inactive, the fault count is zero and the upper limit is armed.
- R2: With the upper limit armed, a valid result with `temp >= lim_hi` is a fault. With the lower limit armed, a valid result with `temp < lim_lo` is a fault.
- R3: `fq_sel` values 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive faulting results. The output changes at the clock edge that samples the last fault of the run.
- R4: A valid non-faulting result resets the fault count. Cycles without `temp_vld` neither count nor reset.
- R5: With `mode_int = 0`, the alert is active exactly while the lower limit is armed. It becomes active after a qualified run at or above `lim_hi`, and it becomes inactive after a qualified run below `lim_lo`.
- R6: With `mode_int = 0`, `rd_ack` has no effect on the alert.
- R7: With `mode_int = 1`, each qualified run latches the alert active and swaps the armed limit. The alert then stays active until `rd_ack`.
- R8: `rd_ack` clears a latched interrupt alert on the next edge. If a trip happens in the same cycle, the alert stays active.
- R9: In interrupt mode, after an alert raised by the upper limit is cleared, a further result at or above `lim_hi` raises nothing. The next alert needs a qualified run below `lim_lo`.
- R10: With `pol = 0` the pin is low when the alert is active. With `pol = 1` the pin is high when the alert is active.
- R11: All comparisons between the temperature and the limits are signed two's-complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_vld | input | 1 | One-cycle strobe marking a new result |
| temp | input | 12 | Signed temperature result |
| lim_hi | input | 12 | Signed upper limit |
| lim_lo | input | 12 | Signed lower limit |
| fq_sel | input | 2 | Consecutive-fault count select |
| mode_int | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| pol | input | 1 | Output polarity, 1 = active high |
| rd_ack | input | 1 | Read pulse that clears an interrupt alert |
| alert_pin | output | 1 | Alert output |

## Verification
A fault count that is not cleared by a passing result shows up at the pin as an alert that fires early, one result short of the qualified run. The fault can be seen on the very edge of that premature trip. A wrong armed limit shows up as an alert that never clears in comparator mode, or as one that re-fires on the wrong side in interrupt mode. It can be seen within one qualified run after the first trip. Interrupt latch errors appear one edge after a read or a trip, when the pin either fails to return or fails to hold.

// File: rtl/therm_pkg.sv
package therm_pkg;
   typedef enum logic {
      ARM_HI = 1'b0,
      ARM_LO = 1'b1
   } arm_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/therm_cmp.sv
module therm_cmp
   import therm_pkg::*;
#(
   parameter int TW         = 12,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] lim_hi,
   input  logic [TW-1:0] lim_lo,
   input  arm_t          arm,
   output logic          fault
);
   logic at_or_above_hi;
   logic below_lo;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("therm_cmp: TW must be at least 2");
      end
      if (SIGNED_CMP) begin : g_signed
         assign at_or_above_hi = $signed(temp) >= $signed(lim_hi);
         assign below_lo       = $signed(temp) <  $signed(lim_lo);
      end else begin : g_unsigned
         assign at_or_above_hi = temp >= lim_hi;
         assign below_lo       = temp <  lim_lo;
      end
   endgenerate

   assign fault = (arm == ARM_HI) ? at_or_above_hi : below_lo;
endmodule

// File: rtl/therm_fault_q.sv
module therm_fault_q #(
   parameter int Q0 = 1,
   parameter int Q1 = 2,
   parameter int Q2 = 4,
   parameter int Q3 = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_vld,
   input  logic       fault,
   input  logic [1:0] fq_sel,
   output logic       trip
);
   localparam int QMAX = therm_pkg::max4(Q0, Q1, Q2, Q3);
   localparam int CW   = $clog2(QMAX + 1);

   generate
      if (Q0 < 1 || Q1 < 1 || Q2 < 1 || Q3 < 1) begin : g_bad_q
         $error("therm_fault_q: every queue depth must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] n_sel;

   always_comb begin
      unique case (fq_sel)
         2'd0:    n_sel = CW'(Q0);
         2'd1:    n_sel = CW'(Q1);
         2'd2:    n_sel = CW'(Q2);
         default: n_sel = CW'(Q3);
      endcase
   end

   assign cnt_inc = cnt + 1'b1;
   assign trip    = smp_vld & fault & (cnt_inc >= n_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (smp_vld) begin
         if (!fault || trip) cnt <= '0;
         else                cnt <= cnt_inc;
      end
   end

   // R4: a passing valid result empties the queue
   a_r4_pass_clears: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld && !fault |=> cnt == '0);
   // R4: idle cycles leave the count alone
   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(cnt));
   // R3: a trip always leaves the queue empty
   a_r3_trip_empties: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> cnt == '0);
endmodule

// File: rtl/therm_alert_st.sv
module therm_alert_st
   import therm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic mode_int,
   input  logic rd_ack,
   output arm_t arm,
   output logic active
);
   logic int_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm   <= ARM_HI;
         int_q <= 1'b0;
      end else begin
         if (trip) arm <= (arm == ARM_HI) ? ARM_LO : ARM_HI;
         if (mode_int && trip) int_q <= 1'b1;
         else if (rd_ack || !mode_int) int_q <= 1'b0;
      end
   end

   assign active = mode_int ? int_q : (arm == ARM_LO);

   // R7: every trip swaps the armed limit
   a_r7_arm_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> arm != $past(arm));
   // R8: a trip wins over a read in the same cycle
   a_r8_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mode_int && trip |=> int_q);
   // R8: a read without a trip clears the latch
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !trip |=> !int_q);
   // R7: the latch only rises because of a trip
   a_r7_rise_from_trip: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_q) |-> $past(trip));
endmodule

// File: rtl/therm_alert.sv
module therm_alert
   import therm_pkg::*;
#(
   parameter int TW         = 12,
   parameter bit SIGNED_CMP = 1'b1,
   parameter int Q0         = 1,
   parameter int Q1         = 2,
   parameter int Q2         = 4,
   parameter int Q3         = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          temp_vld,
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] lim_hi,
   input  logic [TW-1:0] lim_lo,
   input  logic [1:0]    fq_sel,
   input  logic          mode_int,
   input  logic          pol,
   input  logic          rd_ack,
   output logic          alert_pin
);
   arm_t arm;
   logic fault;
   logic trip;
   logic active;

   therm_cmp #(.TW(TW), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .temp   (temp),
      .lim_hi (lim_hi),
      .lim_lo (lim_lo),
      .arm    (arm),
      .fault  (fault)
   );

   therm_fault_q #(.Q0(Q0), .Q1(Q1), .Q2(Q2), .Q3(Q3)) u_fq (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (temp_vld),
      .fault   (fault),
      .fq_sel  (fq_sel),
      .trip    (trip)
   );

   therm_alert_st u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip     (trip),
      .mode_int (mode_int),
      .rd_ack   (rd_ack),
      .arm      (arm),
      .active   (active)
   );

   assign alert_pin = pol ? active : ~active;

   // R5: in comparator mode the alert changes only on a trip
   a_r5_cmp_moves_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_int && $past(!mode_int) && (active != $past(active)) |-> $past(trip));
   // R1: the first cycle after reset shows an inactive alert
   a_r1_reset_idle: assert property (@(posedge clk)
      $past(!rst_n) |-> !active);
endmodule

// File: tb/test_therm_alert.sv
module test_therm_alert;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        temp_vld = 1'b0;
   logic [11:0] temp = '0;
   logic [11:0] lim_hi = 12'd100;
   logic [11:0] lim_lo = 12'd50;
   logic [1:0]  fq_sel = 2'd0;
   logic        mode_int = 1'b0;
   logic        pol = 1'b0;
   logic        rd_ack = 1'b0;
   logic        alert_pin;
   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   therm_alert i_therm_alert (
      .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp(temp),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .fq_sel(fq_sel), .mode_int(mode_int),
      .pol(pol), .rd_ack(rd_ack), .alert_pin(alert_pin)
   );

   task automatic chk(input string req, input logic exp_act);
      logic exp_pin;
      exp_pin = pol ? exp_act : ~exp_act;
      n_chk++;
      if (alert_pin !== exp_pin) begin
         n_fail++;
         $display("FAIL %s: alert_pin=%b expected=%b", req, alert_pin, exp_pin);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; temp_vld = 1'b0; rd_ack = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic smp(input logic [11:0] v);
      @(negedge clk);
      temp = v; temp_vld = 1'b1;
      @(negedge clk);
      temp_vld = 1'b0;
   endtask

   task automatic rd();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic t_reset();
      mode_int = 1'b0; pol = 1'b0; fq_sel = 2'd0;
      do_reset();
      chk("R1 reset inactive", 1'b0);
      pol = 1'b1;
      #1 chk("R10 reset inactive pol1", 1'b0);
      pol = 1'b0;
   endtask

   task automatic t_queue(input logic [1:0] sel, input int n);
      fq_sel = sel; mode_int = 1'b0;
      do_reset();
      for (int i = 0; i < n - 1; i++) smp(12'd120);
      chk("R3 below count high", 1'b0);
      smp(12'd100);
      chk("R3 R5 trip at count (temp == lim_hi)", 1'b1);
      for (int i = 0; i < n - 1; i++) smp(12'd10);
      chk("R3 below count low", 1'b1);
      smp(12'd49);
      chk("R5 cleared below lo", 1'b0);
   endtask

   task automatic t_break();
      fq_sel = 2'd2; mode_int = 1'b0;
      do_reset();
      for (int i = 0; i < 3; i++) smp(12'd200);
      smp(12'd75);
      for (int i = 0; i < 3; i++) smp(12'd200);
      chk("R4 pass restarted count", 1'b0);
      @(negedge clk); temp = 12'd200;
      repeat (5) @(negedge clk);
      chk("R4 idle no count", 1'b0);
      smp(12'd200);
      chk("R4 fourth consecutive trips", 1'b1);
      smp(12'd50);
      chk("R2 lo limit itself not fault", 1'b1);
   endtask

   task automatic t_cmp_rd();
      fq_sel = 2'd0; mode_int = 1'b0;
      do_reset();
      smp(12'd150);
      rd();
      chk("R6 read ignored comparator", 1'b1);
      smp(12'd99);
      chk("R2 hi not armed once active", 1'b1);
   endtask

   task automatic t_pol();
      fq_sel = 2'd0; mode_int = 1'b0; pol = 1'b1;
      do_reset();
      chk("R10 pol1 inactive", 1'b0);
      smp(12'd150);
      chk("R10 pol1 active high", 1'b1);
      pol = 1'b0;
      #1 chk("R10 pol0 active low", 1'b1);
   endtask

   task automatic t_int();
      fq_sel = 2'd0; mode_int = 1'b1; pol = 1'b0;
      do_reset();
      smp(12'd150);
      chk("R7 int alert latched", 1'b1);
      smp(12'd150);
      chk("R7 held until read", 1'b1);
      rd();
      chk("R8 read clears", 1'b0);
      smp(12'd150);
      chk("R9 high after clear no alert", 1'b0);
      smp(12'd20);
      chk("R9 low run raises alert", 1'b1);
      rd();
      chk("R8 read clears again", 1'b0);
      @(negedge clk);
      temp = 12'd150; temp_vld = 1'b1; rd_ack = 1'b1;
      @(negedge clk);
      temp_vld = 1'b0; rd_ack = 1'b0;
      chk("R8 trip wins over read", 1'b1);
      mode_int = 1'b0;
   endtask

   task automatic t_signed();
      fq_sel = 2'd1; mode_int = 1'b0; pol = 1'b0;
      lim_hi = 12'hFFB;  // -5
      lim_lo = 12'hFEC;  // -20
      do_reset();
      smp(12'hFFD); smp(12'hFFD);  // -3
      chk("R11 negative above hi trips", 1'b1);
      smp(12'hFE2); smp(12'h7FF);  // -30 then +2047
      chk("R11 positive is not below lo", 1'b1);
      smp(12'hFE2); smp(12'hFE2);
      chk("R11 negative below lo clears", 1'b0);
      lim_hi = 12'd100; lim_lo = 12'd50;
   endtask

   initial begin
      t_reset();
      t_queue(2'd0, 1);
      t_queue(2'd1, 2);
      t_queue(2'd2, 4);
      t_queue(2'd3, 6);
      t_break();
      t_cmp_rd();
      t_pol();
      t_int();
      t_signed();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule